// File: doc/BRIEF.md
# Chained Configuration Boot Loader

This block is the master-side boot sequencer for a chain of up to sixteen identical devices that take their configuration from one byte-wide external ROM. Each device owns a 128-byte region of the ROM. The loader places a 7-bit byte offset and a 4-bit block number on the address pins. It then issues one write strobe per byte. Bytes from block 0 go into the local register file. Bytes from higher blocks go down the chain, where the block number is decoded externally into per-device enables.

The number of extra devices is taken from the low nibble of byte 0 of block 0, which is the count field of the first mode register. In the final block, loading stops after register 73. After the master has finished its own block, it hands write ownership down the chain with a token. In a chained system, the loader waits for that token to return from the last device before it releases the active-low programming flag.

A load starts on its own after reset when ROM mode is selected. An idle master in ROM mode also accepts a reload request. In host mode the loader stays quiet.

Top module: `cfg_chain_loader`

## Requirements
- R1: While rst_ni is low, prog_no_o is 1, wr_stb_o is 0 and tok_o is 0. With rom_mode_i high, the first clock edge after reset release starts a load: prog_no_o goes to 0 and the first strobe appears at byte 0 of block 0.
- R2: During a load, wr_stb_o is high on every cycle. rom_addr_o steps by one per strobe, from 0 to 127, with exactly one strobe per byte offset.
- R3: blk_sel_o holds the block number (0 to 15). It is constant within a block and advances by one on the cycle after byte 127.
- R4: The device count is the low 4 bits of the byte read at offset 0 of block 0. With single_i low and count C of 1 to 15, blocks 0 to C are read. The final block ends after offset 73, so C*128+74 strobes occur. A count of 0 reads block 0 only, with 74 strobes.
- R5: With single_i high, only block 0 is read (74 strobes) whatever the count field holds. tok_o stays 0, and prog_no_o returns to 1 on the cycle after the last strobe.
- R6: wr_data_o equals rom_data_i for the presented address. wr_local_o is 1 exactly for strobes in block 0.
- R7: In a chained load, tok_o rises with the first strobe of block 1 and stays high until tok_i is seen. After the last strobe, no strobes occur and prog_no_o stays 0 until tok_i is 1 at a clock edge. From the next cycle, prog_no_o is 1 and tok_o is 0.
- R8: prog_no_o is 0 from the first strobe until the end of the load, and strobes occur only while it is 0.
- R9: A reload request that is high at a clock edge while the loader is idle and in ROM mode starts a new load on that edge. A request that arrives while a load is running is ignored: the strobe count is unchanged and no new load follows.
- R10: With rom_mode_i low, no strobes occur, prog_no_o stays 1 and reload requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rom_mode_i | input | 1 | 1: ROM-driven loading, 0: host-driven |
| single_i | input | 1 | 1: single-device system |
| reload_req_i | input | 1 | Reload request (decoded chip enable) |
| rom_data_i | input | 8 | Byte read from the ROM |
| tok_i | input | 1 | Token returned by the last device |
| rom_addr_o | output | 7 | Byte offset within the block |
| blk_sel_o | output | 4 | Block number, upper ROM address bits |
| wr_stb_o | output | 1 | Write strobe, one per byte |
| wr_local_o | output | 1 | Current byte goes to the local register file |
| wr_data_o | output | 8 | Byte to write |
| tok_o | output | 1 | Token to the next device |
| prog_no_o | output | 1 | Programming in progress, active low |

## Verification
The ROM is asynchronous, so a strobe, its address and its data appear together in the cycle that the load state and counters define. The first strobe is due one edge after the idle reload or the reset release. Byte n of a load falls n cycles later. The bench samples every output on the falling edge and compares each strobe against the n-th expected address, block and ROM byte. The release of the programming flag is due one cycle after the last strobe in an unchained load. In a chained load it is due one cycle after the bench returns the token, which it does a chosen number of idle cycles after the last strobe, so the bench checks that exact cycle. Ignored reloads are checked by counting strobes and by watching the flag for several cycles after the load ends.

// File: rtl/cfg_ld_pkg.sv
`timescale 1ns/1ps
package cfg_ld_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_WTOK = 2'd2
  } ld_state_e;
endpackage

// File: rtl/cfg_byte_ctr.sv
`timescale 1ns/1ps
module cfg_byte_ctr #(
  parameter int W    = 7,
  parameter int LAST = 73,
  parameter int CAP  = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o,
  output logic         at_last_o,
  output logic         at_cap_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o     = cnt_q;
  assign wrap_o    = &cnt_q;
  assign at_last_o = (cnt_q == W'(LAST));
  assign at_cap_o  = (cnt_q == W'(CAP));
endmodule

// File: rtl/cfg_blk_ctr.sv
`timescale 1ns/1ps
module cfg_blk_ctr #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic         cap_i,
  input  logic [W-1:0] cap_val_i,
  input  logic         single_i,
  output logic [W-1:0] blk_o,
  output logic         is_last_o,
  output logic         chained_o
);
  logic [W-1:0] blk_q;
  logic [W-1:0] num_q;
  logic [W-1:0] last_blk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q <= '0;
      num_q <= '0;
    end else if (clr_i) begin
      blk_q <= '0;
      num_q <= '0;
    end else begin
      if (step_i) blk_q <= blk_q + 1'b1;
      if (cap_i)  num_q <= cap_val_i;
    end
  end

  // single systems ignore the captured count
  assign last_blk  = single_i ? '0 : num_q;
  assign blk_o     = blk_q;
  assign is_last_o = (blk_q == last_blk);
  assign chained_o = (last_blk != '0);
endmodule

// File: rtl/cfg_tok_ctl.sv
`timescale 1ns/1ps
module cfg_tok_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic tok_o
);
  logic tok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tok_q <= 1'b0;
    else if (clr_i)  tok_q <= 1'b0;
    else if (set_i)  tok_q <= 1'b1;
  end

  assign tok_o = tok_q;
endmodule

// File: rtl/cfg_chain_loader.sv
`timescale 1ns/1ps
module cfg_chain_loader
  import cfg_ld_pkg::*;
#(
  parameter int BYTE_W   = 7,
  parameter int BLK_W    = 4,
  parameter int DATA_W   = 8,
  parameter int LAST_REG = 73,
  parameter int CNT_IDX  = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rom_mode_i,
  input  logic              single_i,
  input  logic              reload_req_i,
  input  logic [DATA_W-1:0] rom_data_i,
  input  logic              tok_i,
  output logic [BYTE_W-1:0] rom_addr_o,
  output logic [BLK_W-1:0]  blk_sel_o,
  output logic              wr_stb_o,
  output logic              wr_local_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              tok_o,
  output logic              prog_no_o
);
  ld_state_e st_q, st_d;
  logic boot_q;
  logic start, in_load, fin, wrap, at_last, at_cap;
  logic is_last, chained, home_blk;
  logic [BYTE_W-1:0] byte_idx;
  logic [BLK_W-1:0]  blk_idx;

  assign start    = (st_q == ST_IDLE) && rom_mode_i && (boot_q || reload_req_i);
  assign in_load  = (st_q == ST_LOAD);
  assign home_blk = (blk_idx == '0);
  assign fin      = in_load && at_last && is_last;

  cfg_byte_ctr #(.W(BYTE_W), .LAST(LAST_REG), .CAP(CNT_IDX)) u_byte (
    .clk_i, .rst_ni,
    .clr_i     (start),
    .step_i    (in_load),
    .cnt_o     (byte_idx),
    .wrap_o    (wrap),
    .at_last_o (at_last),
    .at_cap_o  (at_cap)
  );

  cfg_blk_ctr #(.W(BLK_W)) u_blk (
    .clk_i, .rst_ni,
    .clr_i     (start),
    .step_i    (in_load && wrap && !fin),
    .cap_i     (in_load && home_blk && at_cap),
    .cap_val_i (rom_data_i[BLK_W-1:0]),
    .single_i  (single_i),
    .blk_o     (blk_idx),
    .is_last_o (is_last),
    .chained_o (chained)
  );

  cfg_tok_ctl u_tok (
    .clk_i, .rst_ni,
    .set_i (in_load && wrap && home_blk && !fin),
    .clr_i (start || ((st_q == ST_WTOK) && tok_i)),
    .tok_o (tok_o)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start) st_d = ST_LOAD;
      ST_LOAD: if (fin)   st_d = chained ? ST_WTOK : ST_IDLE;
      ST_WTOK: if (tok_i) st_d = ST_IDLE;
      default:            st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      boot_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      boot_q <= 1'b0;
    end
  end

  assign rom_addr_o = byte_idx;
  assign blk_sel_o  = blk_idx;
  assign wr_stb_o   = in_load;
  assign wr_local_o = in_load && home_blk;
  assign wr_data_o  = rom_data_i;
  assign prog_no_o  = (st_q == ST_IDLE);
endmodule

// File: rtl/cfg_chain_loader_chk.sv
`timescale 1ns/1ps
module cfg_chain_loader_chk #(
  parameter int BYTE_W = 7,
  parameter int BLK_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rom_mode_i,
  input logic              tok_i,
  input logic [BYTE_W-1:0] rom_addr_o,
  input logic [BLK_W-1:0]  blk_sel_o,
  input logic              wr_stb_o,
  input logic              tok_o,
  input logic              prog_no_o
);
  assert_stb_in_prog_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> !prog_no_o);

  assert_addr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_o && $past(wr_stb_o) && rom_addr_o != '0)
      |-> rom_addr_o == BYTE_W'($past(rom_addr_o) + 1'b1));

  assert_blk_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_o && $past(wr_stb_o) && rom_addr_o != '0) |-> $stable(blk_sel_o));

  assert_blk_adv_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_o && $past(wr_stb_o) && rom_addr_o == '0)
      |-> blk_sel_o == BLK_W'($past(blk_sel_o) + 1'b1));

  assert_tok_return_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(prog_no_o) && $past(tok_o)) |-> $past(tok_i));

  assert_tok_off_home_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_o && blk_sel_o == '0) |-> !tok_o);

  assert_host_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_no_o && !rom_mode_i) |=> prog_no_o);
endmodule

bind cfg_chain_loader cfg_chain_loader_chk #(.BYTE_W(BYTE_W), .BLK_W(BLK_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rom_mode_i (rom_mode_i),
  .tok_i      (tok_i),
  .rom_addr_o (rom_addr_o),
  .blk_sel_o  (blk_sel_o),
  .wr_stb_o   (wr_stb_o),
  .tok_o      (tok_o),
  .prog_no_o  (prog_no_o)
);

// File: tb/cfg_chain_loader_bench.sv
`timescale 1ns/1ps
module cfg_chain_loader_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rom_mode_i = 1'b1;
  logic       single_i = 1'b1;
  logic       reload_req_i = 1'b0;
  logic [7:0] rom_data_i;
  logic       tok_i = 1'b0;
  logic [6:0] rom_addr_o;
  logic [3:0] blk_sel_o;
  logic       wr_stb_o, wr_local_o, tok_o, prog_no_o;
  logic [7:0] wr_data_o;

  logic [7:0] rom_mem [0:2047];
  assign rom_data_i = rom_mem[{blk_sel_o, rom_addr_o}];

  cfg_chain_loader u_cfg_chain_loader (
    .clk_i, .rst_ni, .rom_mode_i, .single_i, .reload_req_i, .rom_data_i, .tok_i,
    .rom_addr_o, .blk_sel_o, .wr_stb_o, .wr_local_o, .wr_data_o, .tok_o, .prog_no_o
  );

  always #10 clk_i = ~clk_i;

  int total = 0, bad = 0;
  bit finished = 0;

  int cyc = 0, n_wr = 0, mon_bad = 0, tok_first = -1, prog_rise = -1, last_wr = -1;
  int tok_cnt = 0, tok_dly = 1;
  bit prog_prev = 1'b1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: every strobe is compared with the n-th expected byte (R2 R3 R6)
  always @(negedge clk_i) begin
    cyc++;
    if (rst_ni) begin
      if (tok_o && tok_first < 0) tok_first = n_wr;
      if (wr_stb_o) begin
        if (rom_addr_o != 7'(n_wr % 128) || blk_sel_o != 4'(n_wr / 128) ||
            wr_data_o != rom_mem[n_wr] || wr_local_o != (n_wr < 128))
          mon_bad++;
        n_wr++;
        last_wr = cyc;
      end
      if (prog_no_o && !prog_prev) prog_rise = cyc;
      prog_prev = prog_no_o;
      // downstream chain model: token returns tok_dly idle cycles after writes end
      if (!tok_o) tok_cnt = 0;
      else if (!wr_stb_o) tok_cnt++;
      tok_i = tok_o && (tok_cnt >= tok_dly);
    end
  end

  task automatic clear_mon();
    n_wr = 0; mon_bad = 0; tok_first = -1; prog_rise = -1; last_wr = -1;
  endtask

  task automatic fill_rom(input int cnt);
    for (int i = 0; i < 2048; i++) rom_mem[i] = 8'($urandom);
    rom_mem[0] = {rom_mem[0][7:4], 4'(cnt)};
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk_i); #1;
      if (prog_no_o) begin ok = 1; break; end
    end
  endtask

  task automatic check_result(input bit sgl, input int cnt, input int dly, input bit ok);
    int exp_n;
    bit chained;
    chained = !sgl && cnt != 0;
    exp_n = chained ? cnt * 128 + 74 : 74;
    chk(ok, "R8", "load ends", ok, 1);
    chk(n_wr == exp_n, sgl ? "R5" : "R4", "strobe count", n_wr, exp_n);
    chk(mon_bad == 0, "R2/R3/R6", "strobe addr/block/data/local mismatches", mon_bad, 0);
    if (chained) begin
      chk(tok_first == 128, "R7", "token rise at strobe index", tok_first, 128);
      chk(prog_rise == last_wr + dly + 1, "R7", "flag release cycle", prog_rise, last_wr + dly + 1);
    end else begin
      chk(tok_first == -1, "R5", "token stays low", tok_first, -1);
      chk(prog_rise == last_wr + 1, "R5", "flag release cycle", prog_rise, last_wr + 1);
    end
    chk(tok_o == 1'b0, "R7", "token low after load", tok_o, 0);
  endtask

  task automatic run_load(input bit sgl, input int cnt, input int dly, input bit poke);
    bit ok;
    int n_end;
    fill_rom(cnt);
    single_i = sgl; tok_dly = dly;
    @(negedge clk_i); #1;
    clear_mon();
    reload_req_i = 1'b1;
    @(negedge clk_i); #1;
    reload_req_i = 1'b0;
    chk(!prog_no_o && wr_stb_o && rom_addr_o == 0, "R9", "idle reload starts load",
        {prog_no_o, wr_stb_o}, 1);
    if (poke) begin
      repeat (60) @(negedge clk_i);
      #1 reload_req_i = 1'b1;
      @(negedge clk_i); #1;
      reload_req_i = 1'b0;
    end
    wait_done(ok);
    check_result(sgl, cnt, dly, ok);
    n_end = n_wr;
    repeat (4) @(negedge clk_i);
    #1;
    chk(prog_no_o && n_wr == n_end, "R9", "no new load after end", n_wr, n_end);
  endtask

  initial begin
    bit ok;
    void'($urandom(32'h5eed));
    fill_rom(0);
    rom_mode_i = 1'b1; single_i = 1'b1;
    repeat (3) @(negedge clk_i);
    #1;
    chk(prog_no_o == 1'b1, "R1", "prog flag in reset", prog_no_o, 1);
    chk(wr_stb_o == 1'b0, "R1", "strobe in reset", wr_stb_o, 0);
    chk(tok_o == 1'b0, "R1", "token in reset", tok_o, 0);

    // boot load after reset, single system with non-zero count field (R1 R5)
    fill_rom(5);
    clear_mon();
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk(!prog_no_o && wr_stb_o && blk_sel_o == 0 && rom_addr_o == 0, "R1", "boot load starts",
        {prog_no_o, wr_stb_o}, 1);
    wait_done(ok);
    check_result(1'b1, 5, 1, ok);

    // directed corners
    run_load(1'b0, 1, 1, 1'b0);    // R4 one extra device
    run_load(1'b0, 15, 3, 1'b0);   // R4 maximum chain
    run_load(1'b0, 0, 2, 1'b0);    // R4 zero count
    run_load(1'b0, 2, 5, 1'b1);    // R9 reload while busy ignored
    run_load(1'b1, 9, 1, 1'b1);    // R5 R9 single, busy reload

    // constrained random chains
    for (int k = 0; k < 5; k++)
      run_load(1'($urandom_range(0, 1)), int'($urandom_range(0, 15)),
               int'($urandom_range(1, 6)), 1'($urandom_range(0, 1)));

    // host mode: quiet (R10)
    rom_mode_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i); #1;
    clear_mon();
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    #1 reload_req_i = 1'b1;
    @(negedge clk_i); #1;
    reload_req_i = 1'b0;
    repeat (10) @(negedge clk_i);
    #1;
    chk(n_wr == 0, "R10", "host mode strobes", n_wr, 0);
    chk(prog_no_o == 1'b1 && prog_rise == -1, "R10", "host mode flag", prog_no_o, 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule